// File: doc/BRIEF.md
# Parallel host-bus cycle master

This block turns one read or write request at a time from an on-chip agent into a complete cycle on an external parallel host bus. It drives an address-latch enable, an active-low chip select, active-low write and read/output-enable strobes and, when lanes are enabled, active-low byte-lane selects. A mode input picks how address and data reach the pins. In shared mode the address goes out on the data pins during a latch phase, and the data follows on the same pins. In split mode the address has its own pins and the data pins carry only data.

A wait-state count lengthens the strobe in steps of two clocks. A read samples the data pins in the last strobe clock, so the value is taken at the strobe's trailing edge. Completion of either kind of cycle is marked by a one-clock done pulse, and read data is valid on that pulse. The requester uses valid/ready and may present a new request only while the block is idle.

Top module: `hbus_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `done`=0, `bus_ale`=0, `bus_cs_n`=`bus_wr_n`=`bus_rd_n`=1, `bus_bsel_n` all ones, `dq_oe`=0.
- R2: `req_ready` is 1 only while idle. A request offered while a cycle is in progress is ignored and changes none of the outputs of the cycle under way.
- R3: `bus_ale` is high for exactly one clock, the first clock after the request is accepted. `bus_addr` carries the accepted address from that clock through the done clock.
- R4: `cfg_mode`=0 (shared) puts the address on `dq_out` with `dq_oe`=1 during the latch clock. It then inserts one turnaround clock with `bus_cs_n` and both strobes high. `cfg_mode`=1 (split) starts the strobe in the clock right after the latch clock.
- R5: With wait count N (`cfg_wait`, 0..3), `bus_cs_n` is low for exactly 2+2N consecutive clocks, and the strobe is low over exactly the same clocks.
- R6: A write (`req_write`=1) pulls only `bus_wr_n` low. A read pulls only `bus_rd_n` low.
- R7: For a write, `dq_oe`=1 and `dq_out` carries the write data from the first non-address clock through the strobe and for one more clock after the strobe ends. For a read, `dq_oe`=0 outside the shared-mode latch clock.
- R8: Read data is the value on `dq_in` during the last strobe clock. Values present earlier in the strobe are discarded. It appears on `rdata` with `done` and is held until the next read.
- R9: `done` is a one-clock pulse in the clock after the strobe ends. `req_ready` returns to 1 in the following clock.
- R10: `bus_bsel_n` is low only during the strobe and only when `cfg_wide`=1. In that case a write drives bit i low exactly when `req_be[i]`=1, and a read drives both bits low. When `cfg_wide`=0 they stay all ones.
- R11: When `cfg_wide`=0 (8-bit mode) the upper byte of captured `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 shared address/data pins, 1 split pins; sampled at accept |
| cfg_wide | input | 1 | 1 = 16-bit with byte lanes, 0 = 8-bit; sampled at accept |
| cfg_wait | input | 2 | Wait-state count N; sampled at accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables for writes |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read / output-enable strobe, active low |
| bus_bsel_n | output | 2 | Byte-lane selects, active low |
| bus_addr | output | 16 | Dedicated address pins |
| dq_out | output | 16 | Data-pin drive value |
| dq_oe | output | 1 | Data-pin drive enable |
| dq_in | input | 16 | Data-pin sampled value |

## Verification
The accept edge is cycle zero. The latch clock is cycle 0, the turnaround (shared mode only) is cycle 1, and the strobe spans the next 2+2N cycles. Done follows in the cycle after, and ready returns one cycle later. The bench derives every one of these indices from mode and wait count, compares every output once per cycle at the falling edge, and writes `dq_in` at the falling edge so that only the last strobe cycle carries the expected read value. The sweep covers every mode, width, wait count and direction while junk requests are kept pending during each cycle.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_TURN = 3'd2,
    ST_STRB = 3'd3,
    ST_HOLD = 3'd4
  } hb_state_e;

  localparam logic MODE_SHARED = 1'b0;
  localparam logic MODE_SPLIT  = 1'b1;

  // strobe length in clocks for a given wait count
  function automatic int unsigned strobe_cycles(input int unsigned ws);
    return 32'd2 + 32'd2 * ws;
  endfunction

endpackage

// File: rtl/hbm_seq.sv
module hbm_seq
  import hbm_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_q,
  input  logic [WAIT_W-1:0] wait_q,
  output hb_state_e         state,
  output logic              last_strobe
);
  localparam int CNT_W = WAIT_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val    = CNT_W'(strobe_cycles(int'(wait_q)) - 32'd1);
  assign last_strobe = (state == ST_STRB) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_ADDR;
        ST_ADDR: begin
          if (mode_q == MODE_SHARED) begin
            state <= ST_TURN;
          end else begin
            state <= ST_STRB;
            cnt   <= load_val;
          end
        end
        ST_TURN: begin
          state <= ST_STRB;
          cnt   <= load_val;
        end
        ST_STRB: begin
          if (cnt == '0) state <= ST_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        ST_HOLD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LAST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    last_strobe |=> state == ST_HOLD); // R9
  AST_HOLD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HOLD |=> state == ST_IDLE); // R9
  AST_ADDR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ADDR |=> state != ST_ADDR); // R3

endmodule

// File: rtl/hbm_data.sv
module hbm_data
  import hbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic                cfg_mode,
  input  logic                cfg_wide,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                last_strobe,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [DATA_W-1:0]   wdata_q,
  output logic [DATA_W/8-1:0] be_q,
  output logic                write_q,
  output logic                mode_q,
  output logic                wide_q,
  output logic [WAIT_W-1:0]   wait_q,
  output logic [DATA_W-1:0]   rdata
);
  localparam int LANES = DATA_W / 8;

  logic capture;
  assign capture = last_strobe && !write_q;

  // keep only lane 0 in 8-bit mode
  function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] d,
                                                  input logic wide);
    if (wide) return d;
    return {{(DATA_W-8){1'b0}}, d[7:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
      mode_q  <= MODE_SHARED;
      wide_q  <= 1'b0;
      wait_q  <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        write_q <= req_write;
        mode_q  <= cfg_mode;
        wide_q  <= cfg_wide;
        wait_q  <= cfg_wait;
      end
      if (capture) rdata <= fit_width(dq_in, wide_q);
    end
  end

  if (LANES > 1) begin : g_narrow_chk
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !wide_q) |=> rdata[DATA_W-1:8] == '0); // R11
  end
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata)); // R8
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q) && $stable(write_q)); // R2

endmodule

// File: rtl/hbm_pins.sv
module hbm_pins
  import hbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  hb_state_e           state,
  input  logic                mode_q,
  input  logic                wide_q,
  input  logic                write_q,
  input  logic [DATA_W/8-1:0] be_q,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [DATA_W-1:0]   wdata_q,
  output logic                bus_ale,
  output logic                bus_cs_n,
  output logic                bus_wr_n,
  output logic                bus_rd_n,
  output logic [DATA_W/8-1:0] bus_bsel_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);
  localparam int LANES = DATA_W / 8;

  logic in_strobe;
  logic addr_on_dq;
  assign in_strobe  = (state == ST_STRB);
  assign addr_on_dq = (state == ST_ADDR) && (mode_q == MODE_SHARED);

  function automatic logic [LANES-1:0] lane_sel_n(input logic active, input logic wide,
                                                  input logic wr, input logic [LANES-1:0] be);
    if (!active || !wide) return '1;
    return wr ? ~be : '0;
  endfunction

  always_comb begin
    bus_ale    = (state == ST_ADDR);
    bus_cs_n   = !in_strobe;
    bus_wr_n   = !(in_strobe && write_q);
    bus_rd_n   = !(in_strobe && !write_q);
    bus_bsel_n = lane_sel_n(in_strobe, wide_q, write_q, be_q);
    bus_addr   = addr_q;
    if (addr_on_dq) begin
      dq_out = DATA_W'(addr_q);
      dq_oe  = 1'b1;
    end else begin
      dq_out = wdata_q;
      dq_oe  = write_q && (state != ST_IDLE);
    end
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> (bus_wr_n ^ bus_rd_n)); // R6
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_wr_n && bus_rd_n)); // R5
  AST_NARROW_BSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> &bus_bsel_n); // R10
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> dq_oe && $stable(dq_out)); // R7
  AST_SHARED_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ale) && mode_q == MODE_SHARED) |-> bus_cs_n); // R4

endmodule

// File: rtl/hbus_master.sv
module hbus_master
  import hbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_mode,
  input  logic                cfg_wide,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                bus_ale,
  output logic                bus_cs_n,
  output logic                bus_wr_n,
  output logic                bus_rd_n,
  output logic [DATA_W/8-1:0] bus_bsel_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = WAIT_W + 2;

  hb_state_e         state;
  logic              last_strobe;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              write_q, mode_q, wide_q;
  logic [WAIT_W-1:0] wait_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (state == ST_HOLD);

  hbm_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .mode_q(mode_q),
    .wait_q(wait_q), .state(state), .last_strobe(last_strobe)
  );

  hbm_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .cfg_mode(cfg_mode), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
    .last_strobe(last_strobe), .dq_in(dq_in), .addr_q(addr_q),
    .wdata_q(wdata_q), .be_q(be_q), .write_q(write_q), .mode_q(mode_q),
    .wide_q(wide_q), .wait_q(wait_q), .rdata(rdata)
  );

  hbm_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .mode_q(mode_q),
    .wide_q(wide_q), .write_q(write_q), .be_q(be_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_bsel_n(bus_bsel_n),
    .bus_addr(bus_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // chip-select low-time counter for the width check
  logic [CNT_W-1:0] cs_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         cs_run <= '0;
    else if (!bus_cs_n) cs_run <= cs_run + 1'b1;
    else                cs_run <= '0;
  end

  AST_CS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> cs_run == CNT_W'(strobe_cycles(int'(wait_q)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !bus_ale); // R2

endmodule

// File: tb/sim_hbus_master.sv
module sim_hbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0, cfg_wide = 1'b0;
  logic [1:0]  cfg_wait = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, done;
  logic [15:0] rdata;
  logic        bus_ale, bus_cs_n, bus_wr_n, bus_rd_n;
  logic [1:0]  bus_bsel_n;
  logic [15:0] bus_addr, dq_out, dq_in = '0;
  logic        dq_oe;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hbus_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .cfg_wait(cfg_wait), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .done(done), .rdata(rdata), .bus_ale(bus_ale),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_bsel_n(bus_bsel_n), .bus_addr(bus_addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic mode, input logic wide, input int ws, input logic wr,
                         input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    int turn = (mode == 1'b0) ? 1 : 0;
    int sb   = 1 + turn;
    int se   = sb + 2 + 2 * ws;
    logic [15:0] fin = a ^ 16'h5A3C;
    @(negedge clk);
    cfg_mode = mode; cfg_wide = wide; cfg_wait = 2'(ws);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    dq_in = ~fin;
    chk("R2 ready idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    for (int c = 0; c <= se + 1; c++) begin
      @(negedge clk);
      // junk request kept pending while busy (R2)
      req_valid = (c < se); req_addr = ~a; req_write = ~wr; req_wdata = ~d;
      dq_in = (c == se - 1) ? fin : ~fin;
      if (c <= se) begin
        logic instrb = (c >= sb) && (c < se);
        logic exp_oe = (c == 0) ? (mode == 1'b0 || wr) : wr;
        logic [1:0] exp_bs = (instrb && wide) ? (wr ? ~be : 2'b00) : 2'b11;
        chk("R3 ale", 32'(bus_ale), 32'(c == 0));
        chk("R5 cs_n", 32'(bus_cs_n), 32'(!instrb));
        chk("R6 wr_n/rd_n", 32'({bus_wr_n, bus_rd_n}),
            32'({!(instrb && wr), !(instrb && !wr)}));
        chk("R10 bsel_n", 32'(bus_bsel_n), 32'(exp_bs));
        chk("R9 done", 32'(done), 32'(c == se));
        chk("R2 busy ready", 32'(req_ready), 32'd0);
        chk("R3 bus_addr", 32'(bus_addr), 32'(a));
        chk("R4 dq_oe", 32'(dq_oe), 32'(exp_oe));
        if (exp_oe) begin
          if (c == 0 && mode == 1'b0) chk("R4 addr on dq", 32'(dq_out), 32'(a));
          else                        chk("R7 write data", 32'(dq_out), 32'(d));
        end
        if (c == se && !wr) begin
          if (wide) chk("R8 rdata", 32'(rdata), 32'(fin));
          else      chk("R11 rdata narrow", 32'(rdata), 32'({8'h00, fin[7:0]}));
        end
      end else begin
        chk("R9 ready back", 32'(req_ready), 32'd1);
        chk("R2 no junk start", 32'({bus_ale, done}), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs",
        32'({req_ready, done, bus_ale, bus_cs_n, bus_wr_n, bus_rd_n, bus_bsel_n, dq_oe}),
        32'({1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({req_ready, bus_cs_n, dq_oe}), 32'({1'b1, 1'b1, 1'b0}));
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int ws = 0; ws < 4; ws++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [15:0] a = 16'h1000 + 16'(idx) * 16'h0137;
            logic [15:0] d = 16'hC0DE ^ (16'(idx) * 16'h0A11);
            run_txn(1'(m), 1'(w), ws, 1'(wr), a, d, 2'(idx));
            idx++;
          end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule